// File: doc/BRIEF.md
# Dual-Port RAM with Mailbox Interrupts and Collision Flags

This block is a synchronous RAM with two fully independent access ports, A and B, that share one clock. Each port can read or write any word in every cycle. A read returns its data one cycle after the request. When both ports write the same word in the same cycle, port A's data is stored.

The two topmost words double as mailboxes, so each port can wake the other. A write by port B to the second-highest word raises the interrupt output of port A. Port A clears that interrupt by reading the same word. The highest word works the same way in the opposite direction.

When both ports touch the same word in one cycle, the block raises a collision flag on each port whose access was disturbed. A port is flagged when the other port wrote that word. The flag comes out of a two-stage pipeline, so burst controllers can look back and retry the affected access.

Top module: `dpram_mbox_top`

## Requirements
- R1: A write on either port stores its data. A read on either port presents the stored word on that port's read data output one cycle after the request. Read data holds its value while the port is not reading.
- R2: If one port reads a word in the same cycle that the other port writes it, the read returns the contents from before the write.
- R3: If both ports write the same word in the same cycle, port A's data is stored.
- R4: If both ports read the same word in the same cycle, neither collision output is raised.
- R5: If one port reads a word while the other port writes it, only the reading port's collision output is raised.
- R6: If both ports write the same word in the same cycle, both collision outputs are raised.
- R7: A collision output pulses high for exactly one cycle, two cycles after the colliding access. Accesses to different words raise no flag. A port whose enable is low takes part in no collision.
- R8: A write by port B to address 2^ADDR_W-2 sets `a_irq` in the next cycle. A read of that address by port A clears `a_irq` in the next cycle. Otherwise `a_irq` holds its value.
- R9: A write by port A to address 2^ADDR_W-1 sets `b_irq` in the next cycle. A read of that address by port B clears `b_irq` in the next cycle. Otherwise `b_irq` holds its value.
- R10: If a mailbox is set and cleared in the same cycle, the set wins. A port that writes its own mailbox does not change its own interrupt.
- R11: While reset is held low, both read data outputs, both interrupts and both collision outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Active-low reset for outputs and flags |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, one cycle latency |
| a_irq | output | 1 | Port A mailbox interrupt |
| a_coll | output | 1 | Port A collision flag, two cycles late |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data, one cycle latency |
| b_irq | output | 1 | Port B mailbox interrupt |
| b_coll | output | 1 | Port B collision flag, two cycles late |

## Verification
The bench first goes after the same-word cases, in each direction.
- A read during a write by the other port must return the old data. A write-first array would return the new word instead.
- A double write must keep port A's data. Reversed priority would store port B's word.
- The collision flag must land on the reading port only. A design that flags whichever port writes would mark the wrong port.
- A pair of reads must raise no flag.

Back-to-back collisions check that each flag is a single pulse exactly two cycles late; an off-by-one pipeline would show it one cycle early or late. A disabled port with its write line high checks that the enable gates collisions.

The mailbox checks cover the following cases:
- A clear that coincides with a new message must keep the interrupt set.
- A port writing its own mailbox must leave its own interrupt unchanged. A design that decodes the mailbox address without regard to the writer would change it.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    // One flag per port, used for interrupts and collision stages
    typedef struct packed {
        logic a;
        logic b;
    } port_pair_t;

endpackage

// File: rtl/dpram_array.sv
module dpram_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
    } rd_t;

    logic [DATA_W-1:0] mem_q [DEPTH];
    rd_t rd_d, rd_q;

    // Read path: array is sampled before this edge's writes land
    always_comb begin
        rd_d = rd_q;
        if (a_en && !a_we) rd_d.a = mem_q[a_addr];
        if (b_en && !b_we) rd_d.b = mem_q[b_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    // Write path: port A assigned last so it wins a same-word write
    always_ff @(posedge clk) begin
        if (b_en && b_we) mem_q[b_addr] <= b_wdata;
        if (a_en && a_we) mem_q[a_addr] <= a_wdata;
    end

    assign a_rdata = rd_q.a;
    assign b_rdata = rd_q.b;

    AST_BOTH_WR_A_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && a_we && b_en && b_we && a_addr == b_addr)
        |=> mem_q[$past(a_addr)] == $past(a_wdata)); // R3

endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    output logic              a_irq,
    output logic              b_irq
);
    localparam logic [ADDR_W-1:0] BOX_A = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] BOX_B = {ADDR_W{1'b1}};

    port_pair_t irq_d, irq_q;
    logic set_a, clr_a, set_b, clr_b;

    always_comb begin
        set_a = b_en &&  b_we && (b_addr == BOX_A);
        clr_a = a_en && !a_we && (a_addr == BOX_A);
        set_b = a_en &&  a_we && (a_addr == BOX_B);
        clr_b = b_en && !b_we && (b_addr == BOX_B);
        irq_d   = irq_q;
        irq_d.a = set_a || (irq_q.a && !clr_a);
        irq_d.b = set_b || (irq_q.b && !clr_b);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign a_irq = irq_q.a;
    assign b_irq = irq_q.b;

    AST_A_BOX_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (b_en && b_we && b_addr == BOX_A) |=> a_irq); // R8
    AST_A_BOX_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && !a_we && a_addr == BOX_A && !(b_en && b_we && b_addr == BOX_A))
        |=> !a_irq); // R8
    AST_B_BOX_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && a_we && a_addr == BOX_B) |=> b_irq); // R9
    AST_B_BOX_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (b_en && !b_we && b_addr == BOX_B && !(a_en && a_we && a_addr == BOX_B))
        |=> !b_irq); // R9

endmodule

// File: rtl/dpram_collide.sv
module dpram_collide
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    output logic              a_coll,
    output logic              b_coll
);
    typedef struct packed {
        port_pair_t s1;
        port_pair_t s2;
    } pipe_t;

    pipe_t pipe_d, pipe_q;
    logic  same_word;

    // A port is disturbed only when the other port writes its word
    always_comb begin
        same_word   = a_en && b_en && (a_addr == b_addr);
        pipe_d      = pipe_q;
        pipe_d.s1.a = same_word && b_we;
        pipe_d.s1.b = same_word && a_we;
        pipe_d.s2   = pipe_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign a_coll = pipe_q.s2.a;
    assign b_coll = pipe_q.s2.b;

    AST_RD_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && !a_we && b_en && !b_we && a_addr == b_addr)
        |=> ##1 (!a_coll && !b_coll)); // R4
    AST_A_RD_B_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && !a_we && b_en && b_we && a_addr == b_addr)
        |=> ##1 (a_coll && !b_coll)); // R5
    AST_B_RD_A_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && a_we && b_en && !b_we && a_addr == b_addr)
        |=> ##1 (!a_coll && b_coll)); // R5
    AST_WR_WR_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && a_we && b_en && b_we && a_addr == b_addr)
        |=> ##1 (a_coll && b_coll)); // R6
    AST_NO_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_en && b_en && a_addr == b_addr) |=> ##1 (!a_coll && !b_coll)); // R7

endmodule

// File: rtl/dpram_mbox_top.sv
module dpram_mbox_top #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_irq,
    output logic              a_coll,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_irq,
    output logic              b_coll
);

    dpram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
    );

    dpram_mailbox #(.ADDR_W(ADDR_W)) mbox_i (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr),
        .a_irq(a_irq), .b_irq(b_irq)
    );

    dpram_collide #(.ADDR_W(ADDR_W)) coll_i (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr),
        .a_coll(a_coll), .b_coll(b_coll)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (rst_n || (!a_irq && !b_irq && !a_coll && !b_coll))); // R11

endmodule

// File: tb/dpram_mbox_top_tb.sv
module dpram_mbox_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] BOX_A = AW'(DEPTH - 2);
    localparam logic [AW-1:0] BOX_B = AW'(DEPTH - 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_en = 0, a_we = 0, b_en = 0, b_we = 0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic [DW-1:0] a_rdata, b_rdata;
    logic a_irq, b_irq, a_coll, b_coll;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpram_mbox_top #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_irq(a_irq), .a_coll(a_coll),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_irq(b_irq), .b_coll(b_coll)
    );

    // Scoreboard item: kind 0/1 rdata A/B, 2/3 irq A/B, 4/5 coll A/B
    typedef struct {
        int          due;
        int          kind;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb[$];
    int cyc = 0;
    int checks = 0;
    int fails = 0;
    logic [DW-1:0] ref_mem [DEPTH];
    logic ref_irq_a = 0, ref_irq_b = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic push(input int due, input int kind, input logic [31:0] exp, input string req);
        item_t it;
        it.due = due; it.kind = kind; it.exp = exp; it.req = req;
        sb.push_back(it);
    endtask

    // Monitor: compare every item that falls due in this cycle
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].due == cyc) begin
                    logic [31:0] act;
                    case (sb[i].kind)
                        0: act = 32'(a_rdata);
                        1: act = 32'(b_rdata);
                        2: act = 32'(a_irq);
                        3: act = 32'(b_irq);
                        4: act = 32'(a_coll);
                        default: act = 32'(b_coll);
                    endcase
                    check(sb[i].req, act, sb[i].exp);
                    sb.delete(i);
                end
            end
        end
    end

    // Driver: applies one cycle of stimulus and predicts the results
    task automatic step(input logic ae, input logic awe, input logic [AW-1:0] aa,
                        input logic [DW-1:0] ad, input logic be, input logic bwe,
                        input logic [AW-1:0] ba, input logic [DW-1:0] bd, input string rreq);
        logic hit, set_a, clr_a, set_b, clr_b;
        string ta, tb;
        a_en = ae; a_we = awe; a_addr = aa; a_wdata = ad;
        b_en = be; b_we = bwe; b_addr = ba; b_wdata = bd;
        hit = ae && be && (aa == ba);
        // read data, old contents (R1, R2)
        if (ae && !awe) push(cyc + 1, 0, 32'(ref_mem[aa]), (hit && bwe) ? "R2" : rreq);
        if (be && !bwe) push(cyc + 1, 1, 32'(ref_mem[ba]), (hit && awe) ? "R2" : rreq);
        // mailbox model
        set_a = be && bwe && ba == BOX_A;
        clr_a = ae && !awe && aa == BOX_A;
        set_b = ae && awe && aa == BOX_B;
        clr_b = be && !bwe && ba == BOX_B;
        ref_irq_a = set_a || (ref_irq_a && !clr_a);
        ref_irq_b = set_b || (ref_irq_b && !clr_b);
        push(cyc + 1, 2, 32'(ref_irq_a), (set_a && clr_a) ? "R10" : "R8");
        push(cyc + 1, 3, 32'(ref_irq_b), (set_b && clr_b) ? "R10" : "R9");
        // collision model
        if (!hit)            begin ta = "R7"; tb = "R7"; end
        else if (awe && bwe) begin ta = "R6"; tb = "R6"; end
        else if (awe || bwe) begin ta = "R5"; tb = "R5"; end
        else                 begin ta = "R4"; tb = "R4"; end
        push(cyc + 2, 4, 32'(hit && bwe), ta);
        push(cyc + 2, 5, 32'(hit && awe), tb);
        // array model, port A last so it wins (R3)
        if (be && bwe) ref_mem[ba] = bd;
        if (ae && awe) ref_mem[aa] = ad;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        step(0, 0, '0, '0, 0, 0, '0, '0, "R1");
    endtask

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                if (!done) begin
                    fails++; checks++;
                    $display("FAIL watchdog: actual hung expected finish");
                    $display("%0d/%0d checks passed", checks - fails, checks);
                    $finish;
                end
            end
        join_none
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", 32'(a_rdata), 32'h0);
        check("R11", 32'(b_rdata), 32'h0);
        check("R11", {30'h0, a_irq, b_irq}, 32'h0);
        check("R11", {30'h0, a_coll, b_coll}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        step(1, 1, 6'd5, 16'h1111, 1, 1, 6'd9, 16'h2222, "R1");
        step(1, 0, 6'd9, 16'h0,    1, 0, 6'd5, 16'h0,    "R1");
        step(1, 0, 6'd5, 16'h0,    1, 1, 6'd5, 16'h3333, "R2");  // R2, R5 A flagged
        step(0, 0, 6'd0, 16'h0,    1, 0, 6'd5, 16'h0,    "R1");
        step(1, 1, 6'd5, 16'hAAAA, 1, 0, 6'd5, 16'h0,    "R2");  // R5 B flagged
        step(1, 1, 6'd7, 16'h7A7A, 1, 1, 6'd7, 16'h7B7B, "R3");  // R6
        step(1, 0, 6'd7, 16'h0,    1, 0, 6'd7, 16'h0,    "R3");  // R4, R3 readback
        step(1, 1, 6'd10, 16'h0A0A, 1, 1, 6'd11, 16'h0B0B, "R1"); // R7 different words
        step(0, 1, 6'd7, 16'hDEAD, 1, 1, 6'd7, 16'h0707, "R7");  // disabled A, R7
        step(1, 0, 6'd7, 16'h0,    0, 0, 6'd0, 16'h0,    "R7");  // A write was ignored
        step(1, 0, 6'd10, 16'h0,   1, 0, 6'd11, 16'h0,   "R1");
        // back-to-back collisions then quiet, R7 pulse shape
        step(1, 1, 6'd3, 16'h0303, 1, 1, 6'd3, 16'h3030, "R3");
        step(1, 0, 6'd3, 16'h0,    1, 0, 6'd3, 16'h0,    "R3");
        step(1, 0, 6'd3, 16'h0,    1, 1, 6'd3, 16'h3131, "R2");
        idle();
        // mailbox A (R8)
        step(0, 0, 6'd0, 16'h0,    1, 1, BOX_A, 16'h00AB, "R8");
        idle();
        step(1, 0, BOX_A, 16'h0,   0, 0, 6'd0, 16'h0,    "R8");
        idle();
        // own-mailbox writes leave own interrupt alone (R10)
        step(1, 1, BOX_A, 16'h0011, 1, 1, BOX_B, 16'h0022, "R10");
        // mailbox B (R9)
        step(1, 1, BOX_B, 16'h00CD, 0, 0, 6'd0, 16'h0,   "R9");
        idle();
        step(1, 1, BOX_B, 16'h00CE, 1, 0, BOX_B, 16'h0,  "R10"); // set beats clear
        step(0, 0, 6'd0, 16'h0,    1, 0, BOX_B, 16'h0,   "R9");
        step(1, 0, BOX_A, 16'h0,   1, 1, BOX_A, 16'h00EF, "R10"); // set beats clear on A
        step(1, 0, BOX_A, 16'h0,   0, 0, 6'd0, 16'h0,    "R8");
        repeat (4) idle();

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule